// File: doc/BRIEF.md
# Pseudo-random fill-and-verify memory tester

This block is a destructive self-test engine for a memory attached to a simple synchronous port. A start pulse latches a base address, a location count, a list of up to four 16-bit seeds and a seed count. For each seed in turn the engine writes every location of the range with words taken from a 16-bit Galois LFSR. After all of those writes it goes back to the base address and replays the same generator from the same seed. It reads each location and compares the word read with the regenerated one. No expected data is stored anywhere. The reference stream is rebuilt on demand.

The run is sequenced by a state machine. `ST_IDLE` waits for start and moves to `ST_LOAD_FILL`. `ST_LOAD_FILL` loads the current seed into the LFSR. It goes to `ST_FINISH` when the length is zero and otherwise to `ST_FILL`. `ST_FILL` issues one write per cycle and goes to `ST_LOAD_CHECK` after the last location. `ST_LOAD_CHECK` reloads the same seed and moves to `ST_CHECK`. `ST_CHECK` issues one read per cycle and goes to `ST_DRAIN` after the last location. `ST_DRAIN` waits for the final read word and moves to `ST_NEXT_SEED`. `ST_NEXT_SEED` either advances to the next seed and returns to `ST_LOAD_FILL`, or goes to `ST_FINISH`. `ST_FINISH` holds done and returns to `ST_LOAD_FILL` on a new start.

Mismatches are counted over the whole run. The first one is captured with its address, the expected word and the observed word. Its flag stays set until the next start.

Top module: `prbs_mem_tester`

## Requirements
- R1: While reset is held, and afterwards until a start, busy, done, error flag, error count and memory request are all zero.
- R2: A start pulse seen while the block is idle or finished latches base, length, seed count and seeds, and busy is high in the next cycle. A start pulse or configuration change while busy has no effect on the run.
- R3: In the fill pass, the block issues exactly one write per cycle to addresses base+i (modulo 2^ADDR_W) for i = 0 to length-1, in ascending order. All writes for a seed come before any read for that seed.
- R4: The word written to offset i is the low DATA_W bits of LFSR state s_i. Here s_0 is the seed and s_{i+1} = (s_i >> 1) XOR (s_i[0] ? 0xB400 : 0), on 16 bits.
- R5: The verify pass restarts at the base address and reads the same addresses in the same order. It compares each read against the regenerated s_i of the same seed.
- R6: A seed of zero is replaced by 0xACE1, in both passes.
- R7: Seeds are used in list order, 0 first, where seed k occupies bits [16k+15:16k] of the seed bus. A seed count of 0 acts as 1, and a count above NUM_SEEDS acts as NUM_SEEDS.
- R8: Read data is taken from the memory one cycle after the read request.
- R9: The first mismatch of a run sets the sticky error flag and captures the failing address, expected word and observed word. Later mismatches leave the captured values unchanged.
- R10: The error count increases by one for every mismatching read, over all seeds, and saturates at 2^ERR_W-1.
- R11: Done rises only after the verify pass of the last seed. Busy falls in the same cycle. Done stays high until the next accepted start, which clears done, the error flag and the error count.
- R12: A length of zero completes with busy high for one cycle and no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| base_i | input | ADDR_W | First address of the range |
| len_i | input | ADDR_W+1 | Number of locations |
| seed_cnt_i | input | CNT_W | Number of seeds to use |
| seeds_i | input | NUM_SEEDS*16 | Packed seed list, seed k in bits [16k+15:16k] |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Write when high, read when low |
| mem_addr_o | output | ADDR_W | Memory address |
| mem_wdata_o | output | DATA_W | Write data |
| mem_rdata_i | input | DATA_W | Read data, one cycle after a read request |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | Run complete |
| err_o | output | 1 | Sticky mismatch flag |
| err_cnt_o | output | ERR_W | Saturating mismatch count |
| fail_addr_o | output | ADDR_W | Address of first mismatch |
| fail_exp_o | output | DATA_W | Expected word at first mismatch |
| fail_obs_o | output | DATA_W | Observed word at first mismatch |

## Verification
The bench builds the block with ADDR_W=8, DATA_W=8, NUM_SEEDS=4 and ERR_W=4. The 8-bit address lets a range start near the top of memory and wrap through zero. The narrow data word checks that only the low LFSR bits reach the memory. The 4-bit error count reaches saturation within a 32-location run. A bench memory model injects a stuck word, a shorted address bit and a floating bus that returns the last written word. The expected capture values for each fault come from a software replay of the same fault.

// File: rtl/prbs_mt_pkg.sv
package prbs_mt_pkg;

    localparam int LFSR_W = 16;
    localparam logic [LFSR_W-1:0] LFSR_MASK = 16'hB400;
    localparam logic [LFSR_W-1:0] SEED_SUB  = 16'hACE1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_FILL,
        ST_FILL,
        ST_LOAD_CHECK,
        ST_CHECK,
        ST_DRAIN,
        ST_NEXT_SEED,
        ST_FINISH
    } mt_state_e;

    function automatic logic [LFSR_W-1:0] lfsr_step(input logic [LFSR_W-1:0] s);
        return (s >> 1) ^ (s[0] ? LFSR_MASK : '0);
    endfunction

endpackage

// File: rtl/mt_lfsr.sv
module mt_lfsr
    import prbs_mt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic              adv_i,
    input  logic [LFSR_W-1:0] seed_i,
    output logic [LFSR_W-1:0] state_o
);

    logic [LFSR_W-1:0] state_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEED_SUB;
        end else if (load_i) begin
            state_q <= (seed_i == '0) ? SEED_SUB : seed_i;
        end else if (adv_i) begin
            state_q <= lfsr_step(state_q);
        end
    end

    assign state_o = state_q;

    // R6
    lfsr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        state_q != '0);

endmodule

// File: rtl/mt_check.sv
module mt_check #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int ERR_W  = 8
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic              rd_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] exp_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              err_o,
    output logic [ERR_W-1:0]  cnt_o,
    output logic [ADDR_W-1:0] fail_addr_o,
    output logic [DATA_W-1:0] fail_exp_o,
    output logic [DATA_W-1:0] fail_obs_o
);

    localparam logic [ERR_W-1:0] CNT_MAX = '1;

    logic              pend_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] exp_q;
    logic              err_q;
    logic [ERR_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] fail_addr_q;
    logic [DATA_W-1:0] fail_exp_q;
    logic [DATA_W-1:0] fail_obs_q;
    logic              miss;

    // read word arrives one cycle after the request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            addr_q <= '0;
            exp_q  <= '0;
        end else begin
            pend_q <= rd_i && !clr_i;
            if (rd_i) begin
                addr_q <= addr_i;
                exp_q  <= exp_i;
            end
        end
    end

    assign miss = pend_q && (rdata_i != exp_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q       <= 1'b0;
            cnt_q       <= '0;
            fail_addr_q <= '0;
            fail_exp_q  <= '0;
            fail_obs_q  <= '0;
        end else if (clr_i) begin
            err_q <= 1'b0;
            cnt_q <= '0;
        end else if (miss) begin
            if (cnt_q != CNT_MAX) begin
                cnt_q <= cnt_q + ERR_W'(1);
            end
            if (!err_q) begin
                err_q       <= 1'b1;
                fail_addr_q <= addr_q;
                fail_exp_q  <= exp_q;
                fail_obs_q  <= rdata_i;
            end
        end
    end

    assign err_o       = err_q;
    assign cnt_o       = cnt_q;
    assign fail_addr_o = fail_addr_q;
    assign fail_exp_o  = fail_exp_q;
    assign fail_obs_o  = fail_obs_q;

    // R9
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_q && $past(err_q)) |->
            ($stable(fail_addr_q) && $stable(fail_exp_q) && $stable(fail_obs_q)));

    // R9
    flag_has_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |-> (cnt_q != '0));

    // R10
    cnt_monotonic_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_i |=> (cnt_q >= $past(cnt_q)));

endmodule

// File: rtl/mt_seq.sv
module mt_seq
    import prbs_mt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_SEEDS = 4,
    localparam int CNT_W = $clog2(NUM_SEEDS) + 1,
    localparam int LEN_W = ADDR_W + 1,
    localparam int IDX_W = (NUM_SEEDS > 1) ? $clog2(NUM_SEEDS) : 1
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ADDR_W-1:0]           base_i,
    input  logic [LEN_W-1:0]            len_i,
    input  logic [CNT_W-1:0]            seed_cnt_i,
    input  logic [NUM_SEEDS*LFSR_W-1:0] seeds_i,
    input  logic [LFSR_W-1:0]           lfsr_i,
    output logic                        lfsr_load_o,
    output logic                        lfsr_adv_o,
    output logic [LFSR_W-1:0]           seed_o,
    output logic                        mem_req_o,
    output logic                        mem_we_o,
    output logic [ADDR_W-1:0]           mem_addr_o,
    output logic [DATA_W-1:0]           mem_wdata_o,
    output logic                        rd_issue_o,
    output logic                        clr_o,
    output logic                        busy_o,
    output logic                        done_o
);

    mt_state_e state_q, state_d;

    logic [ADDR_W-1:0]           base_q;
    logic [LEN_W-1:0]            len_q;
    logic [LEN_W-1:0]            off_q;
    logic [CNT_W-1:0]            cnt_q;
    logic [CNT_W-1:0]            idx_q;
    logic [CNT_W-1:0]            cnt_eff;
    logic [NUM_SEEDS*LFSR_W-1:0] seeds_q;
    logic [LFSR_W-1:0]           seed_arr [NUM_SEEDS];
    logic                        accept;
    logic                        last_off;
    logic                        last_seed;

    for (genvar g = 0; g < NUM_SEEDS; g++) begin : g_seed
        assign seed_arr[g] = seeds_q[g*LFSR_W +: LFSR_W];
    end

    assign seed_o    = seed_arr[idx_q[IDX_W-1:0]];
    assign accept    = start_i && (state_q == ST_IDLE || state_q == ST_FINISH);
    assign last_off  = (off_q == len_q - LEN_W'(1));
    assign last_seed = (idx_q == cnt_q - CNT_W'(1));
    assign clr_o     = accept;

    always_comb begin
        if (seed_cnt_i == '0) begin
            cnt_eff = CNT_W'(1);
        end else if (seed_cnt_i > CNT_W'(NUM_SEEDS)) begin
            cnt_eff = CNT_W'(NUM_SEEDS);
        end else begin
            cnt_eff = seed_cnt_i;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (accept) state_d = ST_LOAD_FILL;
            ST_LOAD_FILL:  state_d = (len_q == '0) ? ST_FINISH : ST_FILL;
            ST_FILL:       if (last_off) state_d = ST_LOAD_CHECK;
            ST_LOAD_CHECK: state_d = ST_CHECK;
            ST_CHECK:      if (last_off) state_d = ST_DRAIN;
            ST_DRAIN:      state_d = ST_NEXT_SEED;
            ST_NEXT_SEED:  state_d = last_seed ? ST_FINISH : ST_LOAD_FILL;
            ST_FINISH:     if (accept) state_d = ST_LOAD_FILL;
            default:       state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        lfsr_load_o = 1'b0;
        lfsr_adv_o  = 1'b0;
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        rd_issue_o  = 1'b0;
        busy_o      = 1'b0;
        done_o      = 1'b0;
        unique case (state_q)
            ST_IDLE: ;
            ST_LOAD_FILL: begin
                busy_o      = 1'b1;
                lfsr_load_o = 1'b1;
            end
            ST_FILL: begin
                busy_o     = 1'b1;
                mem_req_o  = 1'b1;
                mem_we_o   = 1'b1;
                lfsr_adv_o = 1'b1;
            end
            ST_LOAD_CHECK: begin
                busy_o      = 1'b1;
                lfsr_load_o = 1'b1;
            end
            ST_CHECK: begin
                busy_o     = 1'b1;
                mem_req_o  = 1'b1;
                rd_issue_o = 1'b1;
                lfsr_adv_o = 1'b1;
            end
            ST_DRAIN:     busy_o = 1'b1;
            ST_NEXT_SEED: busy_o = 1'b1;
            ST_FINISH:    done_o = 1'b1;
            default: ;
        endcase
    end

    assign mem_addr_o  = base_q + off_q[ADDR_W-1:0];
    assign mem_wdata_o = lfsr_i[DATA_W-1:0];

    // configuration, offset and seed index
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q  <= '0;
            len_q   <= '0;
            cnt_q   <= CNT_W'(1);
            seeds_q <= '0;
            idx_q   <= '0;
            off_q   <= '0;
        end else begin
            if (accept) begin
                base_q  <= base_i;
                len_q   <= len_i;
                cnt_q   <= cnt_eff;
                seeds_q <= seeds_i;
                idx_q   <= '0;
            end else if (state_q == ST_NEXT_SEED && !last_seed) begin
                idx_q <= idx_q + CNT_W'(1);
            end
            if (state_q == ST_LOAD_FILL || state_q == ST_LOAD_CHECK) begin
                off_q <= '0;
            end else if (state_q == ST_FILL || state_q == ST_CHECK) begin
                off_q <= off_q + LEN_W'(1);
            end
        end
    end

    // R3
    fill_addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && mem_we_o && $past(mem_req_o && mem_we_o)) |->
            (mem_addr_o == ADDR_W'($past(mem_addr_o) + 1'b1)));

    // R5
    verify_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_we_o && !$past(mem_req_o)) |-> (mem_addr_o == base_q));

    // R11
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(busy_o));

    // R2
    config_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(base_q) && $stable(len_q) && $stable(cnt_q)));

endmodule

// File: rtl/prbs_mem_tester.sv
module prbs_mem_tester
    import prbs_mt_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int NUM_SEEDS = 4,
    parameter int ERR_W     = 8,
    localparam int CNT_W = $clog2(NUM_SEEDS) + 1
)(
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        start_i,
    input  logic [ADDR_W-1:0]           base_i,
    input  logic [ADDR_W:0]             len_i,
    input  logic [CNT_W-1:0]            seed_cnt_i,
    input  logic [NUM_SEEDS*LFSR_W-1:0] seeds_i,
    output logic                        mem_req_o,
    output logic                        mem_we_o,
    output logic [ADDR_W-1:0]           mem_addr_o,
    output logic [DATA_W-1:0]           mem_wdata_o,
    input  logic [DATA_W-1:0]           mem_rdata_i,
    output logic                        busy_o,
    output logic                        done_o,
    output logic                        err_o,
    output logic [ERR_W-1:0]            err_cnt_o,
    output logic [ADDR_W-1:0]           fail_addr_o,
    output logic [DATA_W-1:0]           fail_exp_o,
    output logic [DATA_W-1:0]           fail_obs_o
);

    logic [LFSR_W-1:0] lfsr_state;
    logic [LFSR_W-1:0] seed_cur;
    logic              lfsr_load;
    logic              lfsr_adv;
    logic              rd_issue;
    logic              clr;

    mt_seq #(
        .ADDR_W    (ADDR_W),
        .DATA_W    (DATA_W),
        .NUM_SEEDS (NUM_SEEDS)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .base_i      (base_i),
        .len_i       (len_i),
        .seed_cnt_i  (seed_cnt_i),
        .seeds_i     (seeds_i),
        .lfsr_i      (lfsr_state),
        .lfsr_load_o (lfsr_load),
        .lfsr_adv_o  (lfsr_adv),
        .seed_o      (seed_cur),
        .mem_req_o   (mem_req_o),
        .mem_we_o    (mem_we_o),
        .mem_addr_o  (mem_addr_o),
        .mem_wdata_o (mem_wdata_o),
        .rd_issue_o  (rd_issue),
        .clr_o       (clr),
        .busy_o      (busy_o),
        .done_o      (done_o)
    );

    mt_lfsr u_lfsr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (lfsr_load),
        .adv_i   (lfsr_adv),
        .seed_i  (seed_cur),
        .state_o (lfsr_state)
    );

    mt_check #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .ERR_W  (ERR_W)
    ) u_check (
        .clk         (clk),
        .rst_n       (rst_n),
        .clr_i       (clr),
        .rd_i        (rd_issue),
        .addr_i      (mem_addr_o),
        .exp_i       (lfsr_state[DATA_W-1:0]),
        .rdata_i     (mem_rdata_i),
        .err_o       (err_o),
        .cnt_o       (err_cnt_o),
        .fail_addr_o (fail_addr_o),
        .fail_exp_o  (fail_exp_o),
        .fail_obs_o  (fail_obs_o)
    );

endmodule

// File: tb/tb_prbs_mem_tester.sv
module tb_prbs_mem_tester;

    localparam int AW = 8;
    localparam int DW = 8;
    localparam int NS = 4;
    localparam int EW = 4;
    localparam int CW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] base_i = '0;
    logic [AW:0]   len_i = '0;
    logic [CW-1:0] seed_cnt_i = '0;
    logic [63:0]   seeds_i = '0;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata = '0;
    logic          busy, done, err;
    logic [EW-1:0] err_cnt;
    logic [AW-1:0] fail_addr;
    logic [DW-1:0] fail_exp, fail_obs;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    prbs_mem_tester #(.ADDR_W(AW), .DATA_W(DW), .NUM_SEEDS(NS), .ERR_W(EW)) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i), .len_i(len_i),
        .seed_cnt_i(seed_cnt_i), .seeds_i(seeds_i),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
        .busy_o(busy), .done_o(done), .err_o(err), .err_cnt_o(err_cnt),
        .fail_addr_o(fail_addr), .fail_exp_o(fail_exp), .fail_obs_o(fail_obs)
    );

    // memory model with fault injection: 0 none, 1 stuck word, 2 address short, 3 floating bus
    logic [7:0] ram [256];
    int         fault_mode = 0;
    logic [7:0] stuck_addr = '0;
    logic [7:0] stuck_mask = '0;
    logic [7:0] bus_last = '0;

    function automatic logic [7:0] phys(input logic [7:0] a, input int fm);
        if (fm == 2) return {a[7:3], a[2] | a[3], a[1:0]};
        return a;
    endfunction

    always @(posedge clk) begin
        if (mem_req && mem_we) begin
            ram[phys(mem_addr, fault_mode)] <= mem_wdata;
            bus_last <= mem_wdata;
        end
        if (mem_req && !mem_we) begin
            if (fault_mode == 3) mem_rdata <= bus_last;
            else if (fault_mode == 1 && mem_addr == stuck_addr) mem_rdata <= ram[mem_addr] | stuck_mask;
            else mem_rdata <= ram[phys(mem_addr, fault_mode)];
        end
    end

    // access trace, sampled away from the active edge
    int         tr_n = 0;
    logic       tr_we   [1024];
    logic [7:0] tr_addr [1024];
    logic [7:0] tr_data [1024];

    always @(negedge clk) begin
        if (rst_n && mem_req) begin
            if (tr_n < 1024) begin
                tr_we[tr_n]   = mem_we;
                tr_addr[tr_n] = mem_addr;
                tr_data[tr_n] = mem_wdata;
            end
            tr_n = tr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_step(input logic [15:0] s);
        return {1'b0, s[15:1]} ^ (s[0] ? 16'hB400 : 16'h0000);
    endfunction

    function automatic logic [15:0] ref_seed(input logic [63:0] seeds, input int k);
        logic [15:0] s;
        s = seeds[k*16 +: 16];
        return (s == 16'h0) ? 16'hACE1 : s;
    endfunction

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(!busy && !done && !err && err_cnt == 0 && !mem_req, "R1", "outputs in reset",
            {busy, done, err, mem_req}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done && !err && err_cnt == 0 && !mem_req, "R1", "outputs after reset",
            {busy, done, err, mem_req}, 0);
    endtask

    task automatic run_case(input string name, input logic [7:0] base, input int len,
                            input int cnt_in, input logic [63:0] seeds, input int fm,
                            input bit disturb);
        int          c;
        int          wait_n;
        int          k;
        int          bad_w;
        int          bad_r;
        int          e_cnt;
        bit          e_err;
        logic [7:0]  e_addr, e_exp, e_obs;
        logic [15:0] st;
        logic [7:0]  a, d, obs, lastw;
        logic [7:0]  sram [256];

        fault_mode = fm;
        c = (cnt_in == 0) ? 1 : ((cnt_in > NS) ? NS : cnt_in);

        @(negedge clk);
        tr_n = 0;
        base_i = base;
        len_i = 9'(len);
        seed_cnt_i = 3'(cnt_in);
        seeds_i = seeds;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy == 1'b1, "R2", {name, " busy after start"}, busy, 1);
        chk(done == 1'b0, "R11", {name, " done cleared by start"}, done, 0);
        if (disturb) begin
            repeat (3) @(negedge clk);
            start_i = 1'b1;
            base_i = base ^ 8'hFF;
            len_i = 9'd1;
            seed_cnt_i = 3'd1;
            @(negedge clk);
            start_i = 1'b0;
        end
        wait_n = 0;
        while (!done && wait_n < 20000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(done == 1'b1 && busy == 1'b0, "R11", {name, " completes, busy low"}, {done, busy}, 2'b10);
        repeat (4) @(negedge clk);
        chk(done && !busy && !mem_req, "R11", {name, " done held"}, {done, busy, mem_req}, 3'b100);

        // reference replay of the run, including the injected fault
        k = 0; bad_w = 0; bad_r = 0; e_cnt = 0; e_err = 0;
        e_addr = '0; e_exp = '0; e_obs = '0; lastw = '0;
        for (int s = 0; s < c; s++) begin
            st = ref_seed(seeds, s);
            for (int i = 0; i < len; i++) begin
                a = base + 8'(i);
                sram[phys(a, fm)] = st[7:0];
                lastw = st[7:0];
                if (k >= 1024 || k >= tr_n || !tr_we[k] || tr_addr[k] != a || tr_data[k] != st[7:0])
                    bad_w++;
                k++;
                st = ref_step(st);
            end
            st = ref_seed(seeds, s);
            for (int i = 0; i < len; i++) begin
                a = base + 8'(i);
                d = st[7:0];
                if (fm == 3) obs = lastw;
                else if (fm == 1 && a == stuck_addr) obs = sram[a] | stuck_mask;
                else obs = sram[phys(a, fm)];
                if (obs != d) begin
                    e_cnt++;
                    if (!e_err) begin
                        e_err = 1'b1; e_addr = a; e_exp = d; e_obs = obs;
                    end
                end
                if (k >= 1024 || k >= tr_n || tr_we[k] || tr_addr[k] != a)
                    bad_r++;
                k++;
                st = ref_step(st);
            end
        end
        if (e_cnt > 15) e_cnt = 15;

        chk(tr_n == c * 2 * len, "R7", {name, " access count (R12 when zero)"}, tr_n, c * 2 * len);
        chk(bad_w == 0, "R3/R4/R6", {name, " fill order and data"}, bad_w, 0);
        chk(bad_r == 0, "R5", {name, " verify restart and order"}, bad_r, 0);
        chk(err == e_err, "R8/R9", {name, " error flag"}, err, e_err);
        chk(err_cnt == 4'(e_cnt), "R10", {name, " error count"}, err_cnt, e_cnt);
        if (e_err) begin
            chk(fail_addr == e_addr, "R9", {name, " fail address"}, fail_addr, e_addr);
            chk(fail_exp == e_exp, "R9", {name, " fail expected"}, fail_exp, e_exp);
            chk(fail_obs == e_obs, "R9", {name, " fail observed"}, fail_obs, e_obs);
        end
        fault_mode = 0;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL R11 watchdog: actual run hung expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        // R12 zero length
        run_case("len0", 8'h10, 0, 1, 64'h0000_0000_0000_1234, 0, 1'b0);
        // R4 single seed clean run
        run_case("clean", 8'h20, 16, 1, 64'h0000_0000_0000_1234, 0, 1'b0);
        // R6 zero seed in the middle of the list, R7 order
        run_case("zero-seed", 8'h00, 12, 3, 64'h0000_BEEF_0000_5A5A, 0, 1'b0);
        // R7 count 0 acts as 1, count 7 acts as 4
        run_case("cnt0", 8'h30, 5, 0, 64'h1111_2222_3333_4444, 0, 1'b0);
        run_case("cnt7", 8'h30, 5, 7, 64'h1111_2222_3333_4444, 0, 1'b0);
        // R3 address wrap through zero
        run_case("wrap", 8'hF8, 16, 2, 64'h0000_0000_C0DE_0F0F, 0, 1'b0);
        // R9 stuck word
        stuck_addr = 8'h45;
        stuck_mask = 8'hFF;
        run_case("stuck", 8'h40, 10, 4, 64'h9999_7777_5555_3333, 1, 1'b0);
        // R9 shorted address bit
        run_case("alias", 8'h00, 16, 1, 64'h0000_0000_0000_2468, 2, 1'b0);
        // R10 floating bus, count saturates
        run_case("float", 8'h40, 32, 2, 64'h0000_0000_ABCD_1357, 3, 1'b0);
        // R11 next start clears errors
        run_case("clean-after", 8'h40, 8, 1, 64'h0000_0000_0000_00F1, 0, 1'b0);
        // R2 start and config changes ignored while busy
        run_case("disturb", 8'h80, 20, 2, 64'h0000_0000_4321_8765, 0, 1'b1);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule